// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte working memory of a small 8-bit controller core. The core reaches it in three ways at once. A byte port takes a full 7-bit address. A register port takes a 3-bit register number, which is placed inside one of four eight-byte banks at the bottom of memory. A bit port takes an 8-bit bit address into a sixteen-byte window that starts at byte 20H, and it can test, set, clear or write a single bit. Bytes 30H to 7FH are plain scratch and stack space, and only the byte port reaches them.

A two-bit bank register sits in front of the register port. A strobe loads it, and it resets to bank 0. All reads are registered, so data appears one clock after the request and each read output holds its value until that port is used again. A bit update reads the byte that holds the bit, changes that one bit and writes the byte back in the same clock. The memory has a single write port. When more than one port writes in the same clock, a fixed priority picks one write and the others are lost. Reset clears the bank register and the read outputs, and leaves the stored bytes untouched.

Top module: `banked_dram`

## Requirements
- R1: A byte written through the byte port at any address 00H..7FH is returned on `byte_rdata` one clock after a later read of that address. Each read output keeps its last value while its enable is low.
- R2: A byte-port read and a write in the same cycle return the byte as it was before that write (read-before-write). The same rule holds for the register and bit ports.
- R3: A register access with number n (0..7) touches byte bank*8 + n, where bank is the current value of the bank register. The byte port sees the same storage.
- R4: `bank_we` loads `bank_din` into the bank register at the clock edge. A register access in that same cycle still uses the old bank, and the next access uses the new one. `bank_q` shows the register.
- R5: Reset (synchronous, active low) sets the bank register to 0 and all read outputs to 0. It does not change any stored byte.
- R6: Bit address b (0..127) names bit (b & 7) of byte 20H + (b >> 3). Op code 00 (test) returns that bit on `bit_rdata` one clock later.
- R7: Op 01 sets the bit, op 10 clears it and op 11 writes `bit_wval` into it. The other seven bits of the byte are kept, and the new value can be read on the next cycle.
- R8: A bit access with address 128..255 changes no byte, and `bit_rdata` becomes 0.
- R9: When writes from several ports fall in the same cycle, only one is performed. The bit port (ops 01..11, in range) wins over the register port, and the register port wins over the byte port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_we | input | 1 | Load strobe for the bank register |
| bank_din | input | 2 | New bank number |
| bank_q | output | 2 | Current bank number |
| byte_en | input | 1 | Byte port request |
| byte_we | input | 1 | Byte port write (with byte_en) |
| byte_addr | input | 7 | Byte address |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data, registered |
| reg_en | input | 1 | Register port request |
| reg_we | input | 1 | Register port write (with reg_en) |
| reg_num | input | 3 | Register number within the bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, registered |
| bit_en | input | 1 | Bit port request |
| bit_op | input | 2 | 00 test, 01 set, 10 clear, 11 write |
| bit_addr | input | 8 | Bit address, valid range 0..127 |
| bit_wval | input | 1 | Value for the write op |
| bit_rdata | output | 1 | Bit read data (old value), registered |

## Verification
The assertions assume that the request inputs are at known levels whenever reset is released, and that reset is held across at least one clock edge before the first request. The stimulus never raises an enable while reset is low, and it applies reset both at the start and again in the middle of the run. The assertions also take it for granted that a write comes from at most one port per address at a time, apart from the cycles built to test priority. The directed sections and the mixed random section keep all three ports busy together, so the priority rule is exercised on purpose and not by chance.

// File: rtl/dram_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the banked data RAM.
// Assumes: bit operations are coded on two bits.
package dram_pkg;
    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_PUT  = 2'b11
    } bit_op_e;
endpackage

// File: rtl/dram_bank_reg.sv
`timescale 1ns/1ps
// Module: dram_bank_reg
// Holds the number of the register bank in use. It is loaded by a strobe
// and takes effect from the next clock.
// Assumes: synchronous active-low reset that selects bank 0.
module dram_bank_reg #(
    parameter int NBANK = 4,
    localparam int BKW = $clog2(NBANK)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [BKW-1:0] din,
    output logic [BKW-1:0] q
);
    // Bank register: cleared by reset, loaded on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= din;
    end

    // R5: the bank reads 0 when reset is released
    assert_bank_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));

    // R4: the bank keeps its value unless it is loaded
    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R4: a load shows up on the next cycle
    assert_bank_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din)));
endmodule

// File: rtl/dram_addr_map.sv
`timescale 1ns/1ps
// Module: dram_addr_map
// Turns a register number into a byte index through the bank. It also turns
// a bit address into a byte index, a bit position and a range flag.
// Assumes: the bit window lies fully inside the memory.
module dram_addr_map #(
    parameter int DEPTH     = 128,
    parameter int WIDTH     = 8,
    parameter int NBANK     = 4,
    parameter int NREG      = 8,
    parameter int BIT_BASE  = 32,
    parameter int BIT_BYTES = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int BKW   = $clog2(NBANK),
    localparam int RNW   = $clog2(NREG),
    localparam int PW    = $clog2(WIDTH),
    localparam int NBITS = BIT_BYTES * WIDTH,
    localparam int BAW   = $clog2(NBITS) + 1
) (
    input  logic [BKW-1:0] bank,
    input  logic [RNW-1:0] reg_num,
    input  logic [BAW-1:0] bit_addr,
    output logic [AW-1:0]  reg_idx,
    output logic [AW-1:0]  bit_idx,
    output logic [PW-1:0]  bit_pos,
    output logic           bit_ok
);
    // Register decode: pick the bank, then the slot inside it.
    always_comb begin
        reg_idx = AW'(int'(bank) * NREG + int'(reg_num));
    end

    // Bit decode: byte offset from the top bits, lane from the low bits.
    always_comb begin
        bit_ok  = (int'(bit_addr) < NBITS);
        bit_idx = AW'(BIT_BASE + int'(bit_addr >> PW));
        bit_pos = bit_addr[PW-1:0];
    end
endmodule

// File: rtl/dram_array.sv
`timescale 1ns/1ps
// Module: dram_array
// Byte storage with three registered read ports and one write port shared
// by priority (bit over register over byte). A bit update is a
// read-modify-write done within one clock.
// Assumes: indices come from dram_addr_map; the storage is never reset.
module dram_array #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic             byte_we,
    input  logic [AW-1:0]    byte_addr,
    input  logic [WIDTH-1:0] byte_wdata,
    output logic [WIDTH-1:0] byte_rdata,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_idx,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             bit_en,
    input  dram_pkg::bit_op_e bit_op,
    input  logic             bit_ok,
    input  logic [AW-1:0]    bit_idx,
    input  logic [PW-1:0]    bit_pos,
    input  logic             bit_wval,
    output logic             bit_rdata
);
    import dram_pkg::*;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] bit_old;
    logic [WIDTH-1:0] bit_new;
    logic             lane_val;
    logic             bit_wr;
    logic             reg_wr;
    logic             byte_wr;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [WIDTH-1:0] wr_data;

    // Bit path: fetch the holding byte and pick the new lane value.
    always_comb begin
        bit_old = mem[bit_idx];
        bit_wr  = bit_en && bit_ok && (bit_op != BOP_TEST);
        case (bit_op)
            BOP_SET: lane_val = 1'b1;
            BOP_CLR: lane_val = 1'b0;
            BOP_PUT: lane_val = bit_wval;
            default: lane_val = bit_old[bit_pos];
        endcase
    end

    // Lane merge: only the addressed lane takes the new value.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign bit_new[i] = (bit_pos == PW'(i)) ? lane_val : bit_old[i];
    end

    // Write arbitration: the bit port first, then the register port, then the byte port.
    always_comb begin
        reg_wr  = reg_en && reg_we;
        byte_wr = byte_en && byte_we;
        wr_en   = bit_wr || reg_wr || byte_wr;
        if (bit_wr) begin
            wr_addr = bit_idx;
            wr_data = bit_new;
        end else if (reg_wr) begin
            wr_addr = reg_idx;
            wr_data = reg_wdata;
        end else begin
            wr_addr = byte_addr;
            wr_data = byte_wdata;
        end
    end

    // Storage update: the single write port, with no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read registers: take the old contents and hold while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_rdata <= '0;
            reg_rdata  <= '0;
            bit_rdata  <= 1'b0;
        end else begin
            if (byte_en) byte_rdata <= mem[byte_addr];
            if (reg_en)  reg_rdata  <= mem[reg_idx];
            if (bit_en)  bit_rdata  <= bit_ok ? bit_old[bit_pos] : 1'b0;
        end
    end

    // R2: a byte read in a write cycle returns the older byte
    assert_old_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_en && byte_we) |=> (byte_rdata == $past(mem[byte_addr])));

    // R7: a bit update changes at most one bit of its byte
    assert_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_wr |=> ($countones(mem[$past(bit_idx)] ^ $past(bit_old)) <= 1));

    // R7: a set leaves the addressed bit at one
    assert_bit_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && bit_ok && bit_op == BOP_SET && !$isunknown(bit_idx))
        |=> (mem[$past(bit_idx)][$past(bit_pos)] == 1'b1));

    // R8: an out-of-range bit access reads back zero
    assert_oor_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bit_ok) |=> (bit_rdata == 1'b0));

    // R9: a register write that loses to a bit write leaves its byte unchanged
    assert_reg_loses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr && reg_en && reg_we && reg_idx != bit_idx)
        |=> (mem[$past(reg_idx)] == $past(mem[reg_idx])));
endmodule

// File: rtl/banked_dram.sv
`timescale 1ns/1ps
// Module: banked_dram
// 128-byte internal data RAM with a byte port, a banked register port and
// a bit port that updates one bit of the bit window.
// Assumes: one clock, synchronous active-low reset, requests held low in reset.
module banked_dram #(
    parameter int DEPTH     = 128,
    parameter int WIDTH     = 8,
    parameter int NBANK     = 4,
    parameter int NREG      = 8,
    parameter int BIT_BASE  = 32,
    parameter int BIT_BYTES = 16,
    localparam int AW  = $clog2(DEPTH),
    localparam int BKW = $clog2(NBANK),
    localparam int RNW = $clog2(NREG),
    localparam int PW  = $clog2(WIDTH),
    localparam int BAW = $clog2(BIT_BYTES * WIDTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_we,
    input  logic [BKW-1:0]   bank_din,
    output logic [BKW-1:0]   bank_q,
    input  logic             byte_en,
    input  logic             byte_we,
    input  logic [AW-1:0]    byte_addr,
    input  logic [WIDTH-1:0] byte_wdata,
    output logic [WIDTH-1:0] byte_rdata,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [RNW-1:0]   reg_num,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             bit_en,
    input  logic [1:0]       bit_op,
    input  logic [BAW-1:0]   bit_addr,
    input  logic             bit_wval,
    output logic             bit_rdata
);
    logic [AW-1:0] reg_idx;
    logic [AW-1:0] bit_idx;
    logic [PW-1:0] bit_pos;
    logic          bit_ok;

    dram_bank_reg #(.NBANK(NBANK)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .load (bank_we),
        .din  (bank_din),
        .q    (bank_q)
    );

    dram_addr_map #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .NBANK(NBANK), .NREG(NREG),
        .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
    ) u_map (
        .bank    (bank_q),
        .reg_num (reg_num),
        .bit_addr(bit_addr),
        .reg_idx (reg_idx),
        .bit_idx (bit_idx),
        .bit_pos (bit_pos),
        .bit_ok  (bit_ok)
    );

    dram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_en   (byte_en),
        .byte_we   (byte_we),
        .byte_addr (byte_addr),
        .byte_wdata(byte_wdata),
        .byte_rdata(byte_rdata),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bit_en    (bit_en),
        .bit_op    (dram_pkg::bit_op_e'(bit_op)),
        .bit_ok    (bit_ok),
        .bit_idx   (bit_idx),
        .bit_pos   (bit_pos),
        .bit_wval  (bit_wval),
        .bit_rdata (bit_rdata)
    );

    // R3: a register read returns bank*8+n as seen by the byte port one cycle later
    assert_reg_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && byte_en && !byte_we && !bank_we
         && byte_addr == AW'(int'(bank_q) * NREG + int'(reg_num)))
        |=> (reg_rdata == byte_rdata));
endmodule

// File: tb/test_banked_dram.sv
`timescale 1ns/1ps
// Bench: a behavioural model of the memory, updated once per clock and
// compared with all outputs on every falling edge.
module test_banked_dram;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bank_we;
    logic [1:0] bank_din, bank_q;
    logic       byte_en, byte_we;
    logic [6:0] byte_addr;
    logic [7:0] byte_wdata, byte_rdata;
    logic       reg_en, reg_we;
    logic [2:0] reg_num;
    logic [7:0] reg_wdata, reg_rdata;
    logic       bit_en;
    logic [1:0] bit_op;
    logic [7:0] bit_addr;
    logic       bit_wval, bit_rdata;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] m [128];
    int         mbank = 0;
    logic [7:0] e_byte = 8'h00, e_reg = 8'h00;
    logic       e_bit = 1'b0;

    always #2.5 clk = ~clk;

    banked_dram i_banked_dram (
        .clk(clk), .rst_n(rst_n),
        .bank_we(bank_we), .bank_din(bank_din), .bank_q(bank_q),
        .byte_en(byte_en), .byte_we(byte_we), .byte_addr(byte_addr),
        .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
        .reg_en(reg_en), .reg_we(reg_we), .reg_num(reg_num),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_en(bit_en), .bit_op(bit_op), .bit_addr(bit_addr),
        .bit_wval(bit_wval), .bit_rdata(bit_rdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        bank_we = 0; bank_din = 0;
        byte_en = 0; byte_we = 0; byte_addr = 0; byte_wdata = 0;
        reg_en = 0; reg_we = 0; reg_num = 0; reg_wdata = 0;
        bit_en = 0; bit_op = 0; bit_addr = 0; bit_wval = 0;
    endtask

    // Apply the inputs now on the pins for one clock, update the model, then compare.
    task automatic cyc(input string req);
        int ridx;
        int nbank;
        logic [7:0] tb;
        nbank = mbank;
        if (!rst_n) begin
            nbank = 0; e_byte = 0; e_reg = 0; e_bit = 0;
        end else begin
            ridx = mbank * 8 + int'(reg_num);
            if (bank_we) nbank = int'(bank_din);
            if (byte_en) e_byte = m[byte_addr];
            if (reg_en)  e_reg  = m[ridx];
            if (bit_en)  e_bit  = (bit_addr < 128) ? m[32 + (bit_addr >> 3)][bit_addr[2:0]] : 1'b0;
            if (bit_en && bit_addr < 128 && bit_op != 2'b00) begin
                tb = m[32 + (bit_addr >> 3)];
                case (bit_op)
                    2'b01:   tb[bit_addr[2:0]] = 1'b1;
                    2'b10:   tb[bit_addr[2:0]] = 1'b0;
                    default: tb[bit_addr[2:0]] = bit_wval;
                endcase
                m[32 + (bit_addr >> 3)] = tb;
            end else if (reg_en && reg_we) begin
                m[ridx] = reg_wdata;
            end else if (byte_en && byte_we) begin
                m[byte_addr] = byte_wdata;
            end
        end
        mbank = nbank;
        @(negedge clk);
        check(req, "bank_q", int'(bank_q), mbank);
        check(req, "byte_rdata", int'(byte_rdata), int'(e_byte));
        check(req, "reg_rdata", int'(reg_rdata), int'(e_reg));
        check(req, "bit_rdata", int'(bit_rdata), int'(e_bit));
    endtask

    task automatic wr_byte(input string req, input int a, input int d);
        idle(); byte_en = 1; byte_we = 1; byte_addr = 7'(a); byte_wdata = 8'(d); cyc(req);
    endtask

    task automatic rd_byte(input string req, input int a);
        idle(); byte_en = 1; byte_addr = 7'(a); cyc(req);
    endtask

    task automatic bit_do(input string req, input int op, input int a, input int v);
        idle(); bit_en = 1; bit_op = 2'(op); bit_addr = 8'(a); bit_wval = v[0]; cyc(req);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 8'h00;
        idle();
        rst_n = 0;
        @(negedge clk);
        // Fill every byte so that model and design agree on the contents
        cyc("R5");
        rst_n = 1;
        for (int i = 0; i < 128; i++) wr_byte("R1", i, (i * 37 + 5) & 8'hFF);

        // R1: read back at the ends and in each region
        rd_byte("R1", 0); rd_byte("R1", 8'h1F); rd_byte("R1", 8'h2A);
        rd_byte("R1", 8'h30); rd_byte("R1", 8'h7F);
        idle(); cyc("R1"); // read output holds while idle

        // R2: read and write the same byte in one cycle
        idle(); byte_en = 1; byte_we = 1; byte_addr = 7'h45; byte_wdata = 8'hA5; cyc("R2");
        rd_byte("R2", 8'h45);

        // R3 and R4: write a register while the bank changes, then with the new bank
        idle(); bank_we = 1; bank_din = 2; reg_en = 1; reg_we = 1; reg_num = 3; reg_wdata = 8'h11; cyc("R4");
        idle(); reg_en = 1; reg_we = 1; reg_num = 3; reg_wdata = 8'h22; cyc("R4");
        rd_byte("R3", 8'h03); rd_byte("R3", 8'h13);
        for (int b = 0; b < 4; b++) begin
            idle(); bank_we = 1; bank_din = 2'(b); cyc("R4");
            for (int r = 0; r < 8; r++) begin
                idle(); reg_en = 1; reg_we = 1; reg_num = 3'(r); reg_wdata = 8'(b * 16 + r); cyc("R3");
            end
            idle(); reg_en = 1; reg_num = 7; cyc("R3");
        end
        rd_byte("R3", 8'h1F); rd_byte("R3", 8'h00);

        // R6 and R7: bit ops at both ends of the window and in the middle
        bit_do("R6", 0, 0, 0); bit_do("R6", 0, 127, 0);
        bit_do("R7", 1, 0, 0); bit_do("R7", 2, 127, 0); bit_do("R7", 3, 77, 1);
        bit_do("R7", 3, 78, 0); bit_do("R7", 1, 77, 0);
        bit_do("R6", 0, 0, 0); bit_do("R6", 0, 77, 0);
        rd_byte("R7", 8'h20); rd_byte("R7", 8'h29); rd_byte("R7", 8'h2F);

        // R8: out-of-range bit addresses change nothing and read 0
        bit_do("R8", 1, 128, 0); bit_do("R8", 3, 255, 1); bit_do("R8", 0, 200, 0);
        for (int i = 8'h20; i < 8'h30; i++) rd_byte("R8", i);

        // R9: all three ports write in one cycle
        idle(); bank_we = 1; bank_din = 0; cyc("R9");
        idle(); bit_en = 1; bit_op = 1; bit_addr = 8'd9;
        reg_en = 1; reg_we = 1; reg_num = 5; reg_wdata = 8'h5A;
        byte_en = 1; byte_we = 1; byte_addr = 7'h50; byte_wdata = 8'hC3; cyc("R9");
        idle(); reg_en = 1; reg_we = 1; reg_num = 6; reg_wdata = 8'h66;
        byte_en = 1; byte_we = 1; byte_addr = 7'h51; byte_wdata = 8'h77; cyc("R9");
        rd_byte("R9", 8'h21); rd_byte("R9", 8'h05); rd_byte("R9", 8'h50);
        rd_byte("R9", 8'h06); rd_byte("R9", 8'h51);

        // R5: reset in the middle clears the bank and outputs, keeps the data
        idle(); bank_we = 1; bank_din = 3; cyc("R5");
        rst_n = 0; idle(); cyc("R5"); rst_n = 1;
        rd_byte("R5", 8'h1F); rd_byte("R5", 8'h45);
        idle(); reg_en = 1; reg_num = 3; cyc("R5");

        // Mixed traffic on all ports
        for (int k = 0; k < 3000; k++) begin
            idle();
            bank_we    = ($urandom % 8) == 0;
            bank_din   = 2'($urandom);
            byte_en    = $urandom % 2;
            byte_we    = $urandom % 2;
            byte_addr  = 7'($urandom);
            byte_wdata = 8'($urandom);
            reg_en     = $urandom % 2;
            reg_we     = $urandom % 2;
            reg_num    = 3'($urandom);
            reg_wdata  = 8'($urandom);
            bit_en     = $urandom % 2;
            bit_op     = 2'($urandom);
            bit_addr   = (($urandom % 6) == 0) ? 8'($urandom) : 8'($urandom % 128);
            bit_wval   = $urandom % 2;
            cyc("R9");
        end
        idle(); cyc("R1");
        finish_run();
    end
endmodule